// File: doc/BRIEF.md
# Two-Way Set-Associative Cache Controller

This block is a cache that sits between a processor request port and a slower main-memory port. Every byte address is split into a tag, a set index and a byte offset within a four-byte block. Each set holds two lines. A lookup compares the tags of both lines of the indexed set. A hit is served from the line. A miss reads the whole block from memory, installs it in the least-recently-used line and then completes the access from that line.

Two configuration inputs select the behaviour for each access. The first input disables caching. The second input, when caching is enabled, chooses between write-back and write-through. In write-back mode a write touches only the line and marks it modified. A modified line goes back to memory only when it is displaced. In write-through mode every write also goes to memory as a single-byte write. A write miss in this mode does not allocate a line. With caching disabled, every access goes straight to memory and the line state stays as it was.

The processor holds `cpu_req` and its request fields steady until `cpu_ready` pulses. The memory side moves whole blocks, or single bytes selected by byte enables, under a valid/ready handshake.

Top module: `cache2w`

## Requirements
- R1: A byte address splits into a byte offset in bits [OFF_W-1:0], a set index in the next SET_W bits and a tag in the remaining upper bits. The memory block address is {tag, set}, and byte k of a block occupies bits [8k+7:8k].
- R2: A lookup hits when a valid line in the indexed set has a tag equal to the address tag. A read hit returns the addressed byte with no memory transfer.
- R3: At most one line of a set ever matches a given tag.
- R4: A read miss, or a write-back write miss, performs exactly one block read from memory and installs the block in the victim line. The access then completes from that line as a hit.
- R5: Each set keeps one replacement bit that names its least-recently-used line. Every hit or install makes the other line the next victim, and after reset line 0 is the first victim.
- R6: In write-back mode a write hit updates only the addressed byte of the line and marks the line modified, with no memory transfer. A write miss first fetches the block and then merges the byte.
- R7: Before an install, a victim that is valid and modified is written to memory as one full block (all byte enables set). A clean victim is dropped without a memory write. This holds in any mode.
- R8: In write-through mode every write produces exactly one memory write with only the addressed byte enabled. A write hit also updates the line.
- R9: In write-through mode a write miss allocates no line and reads nothing from memory.
- R10: With caching disabled, a read performs one block read and returns the addressed byte, and a write performs one single-byte memory write. No line, modified bit or replacement bit changes.
- R11: Mode encoding: cfg_cd=1 disables caching whatever cfg_nw is. cfg_cd=0 with cfg_nw=1 selects write-back. cfg_cd=0 with cfg_nw=0 selects write-through. The mode is sampled when a request is accepted.
- R12: cpu_ready is a one-cycle pulse that comes no earlier than the second cycle after acceptance, and cpu_rdata holds the read byte while it is high. mem_valid, mem_we, mem_addr, mem_be and mem_wdata stay steady until mem_ready is seen.
- R13: Reset invalidates every line and clears every replacement bit. During reset neither cpu_ready nor mem_valid is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cd | input | 1 | Cache disable |
| cfg_nw | input | 1 | Selects write-back when caching is enabled |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 = byte write, 0 = byte read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 8 | Write byte |
| cpu_ready | output | 1 | Access complete (one-cycle pulse) |
| cpu_rdata | output | 8 | Read byte |
| mem_valid | output | 1 | Memory transfer request |
| mem_we | output | 1 | Memory transfer is a write |
| mem_addr | output | ADDR_W-OFF_W | Block address |
| mem_be | output | 2**OFF_W | Byte enables for writes |
| mem_wdata | output | 8*2**OFF_W | Block write data |
| mem_ready | input | 1 | Memory accepts or completes the transfer |
| mem_rdata | input | 8*2**OFF_W | Block read data, valid with mem_ready |

## Verification
The bench builds the block with SET_W=2 and keeps the default address and offset widths. That gives four sets of two lines, and the bench uses four distinct tags per set. Conflicts, dirty and clean evictions and replacement-bit turnover therefore occur within a few accesses rather than after thousands. The small geometry lets a bench-side model of every line and a sixteen-block memory image be compared after each access. Random switching between the three modes then reaches mixed states, such as modified lines left behind when the mode changes to write-through or to disabled.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;

  typedef enum logic [1:0] {
    MODE_WT  = 2'd0,
    MODE_WB  = 2'd1,
    MODE_OFF = 2'd2
  } cmode_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOOK  = 3'd1,
    ST_EVICT = 3'd2,
    ST_FILL  = 3'd3,
    ST_MWR   = 3'd4,
    ST_MRD   = 3'd5,
    ST_DONE  = 3'd6
  } cstate_e;

  function automatic cmode_e decode_mode(input logic cd, input logic nw);
    if (cd)      return MODE_OFF;
    else if (nw) return MODE_WB;
    else         return MODE_WT;
  endfunction

endpackage

// File: rtl/cache2w_way.sv
module cache2w_way #(
  parameter int SET_W = 8,
  parameter int TAG_W = 14,
  parameter int BLK_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] rd_set,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  output logic [BLK_W-1:0] rd_data,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  logic             wr_dirty,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [BLK_W-1:0] wr_data
);
  localparam int NSETS = 1 << SET_W;

  logic [NSETS-1:0] valid_q;
  logic [NSETS-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q  [NSETS];
  logic [BLK_W-1:0] data_q [NSETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_set] <= 1'b1;
      dirty_q[wr_set] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_set]  <= wr_tag;
      data_q[wr_set] <= wr_data;
    end
  end

  assign rd_valid = valid_q[rd_set];
  assign rd_dirty = dirty_q[rd_set];
  assign rd_tag   = tag_q[rd_set];
  assign rd_data  = data_q[rd_set];
endmodule

// File: rtl/cache2w_lru.sv
module cache2w_lru #(
  parameter int SET_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] rd_set,
  output logic             victim,
  input  logic             touch,
  input  logic [SET_W-1:0] touch_set,
  input  logic             used_way
);
  localparam int NSETS = 1 << SET_W;

  logic [NSETS-1:0] lru_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     lru_q <= '0;
    else if (touch) lru_q[touch_set] <= ~used_way;
  end

  assign victim = lru_q[rd_set];
endmodule

// File: rtl/cache2w.sv
module cache2w
  import cache2w_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int SET_W  = 8,
  parameter int OFF_W  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_cd,
  input  logic                        cfg_nw,
  input  logic                        cpu_req,
  input  logic                        cpu_we,
  input  logic [ADDR_W-1:0]           cpu_addr,
  input  logic [7:0]                  cpu_wdata,
  output logic                        cpu_ready,
  output logic [7:0]                  cpu_rdata,
  output logic                        mem_valid,
  output logic                        mem_we,
  output logic [ADDR_W-OFF_W-1:0]     mem_addr,
  output logic [(1<<OFF_W)-1:0]       mem_be,
  output logic [8*(1<<OFF_W)-1:0]     mem_wdata,
  input  logic                        mem_ready,
  input  logic [8*(1<<OFF_W)-1:0]     mem_rdata
);
  localparam int TAG_W     = ADDR_W - SET_W - OFF_W;
  localparam int BLK_BYTES = 1 << OFF_W;
  localparam int BLK_W     = 8 * BLK_BYTES;
  localparam int BADDR_W   = ADDR_W - OFF_W;
  localparam int WAYS      = 2;

  // address field and byte lane arithmetic
  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [SET_W-1:0] f_set(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: SET_W];
  endfunction

  function automatic logic [OFF_W-1:0] f_off(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction

  function automatic logic [7:0] f_pick(input logic [BLK_W-1:0] b, input logic [OFF_W-1:0] o);
    return b[{o, 3'b000} +: 8];
  endfunction

  function automatic logic [BLK_W-1:0] f_merge(input logic [BLK_W-1:0] b,
                                               input logic [OFF_W-1:0] o,
                                               input logic [7:0]       d);
    logic [BLK_W-1:0] r;
    r = b;
    r[{o, 3'b000} +: 8] = d;
    return r;
  endfunction

  function automatic logic [BLK_BYTES-1:0] f_be(input logic [OFF_W-1:0] o);
    logic [BLK_BYTES-1:0] r;
    r = '0;
    r[o] = 1'b1;
    return r;
  endfunction

  // captured request
  cstate_e          state_q, state_d;
  logic [ADDR_W-1:0] req_addr_q;
  logic              req_we_q;
  logic [7:0]        req_wdata_q;
  cmode_e            req_mode_q;
  logic [7:0]        resp_q, resp_d;
  logic              resp_ld;

  logic [TAG_W-1:0] r_tag;
  logic [SET_W-1:0] r_set;
  logic [OFF_W-1:0] r_off;
  assign r_tag = f_tag(req_addr_q);
  assign r_set = f_set(req_addr_q);
  assign r_off = f_off(req_addr_q);

  // way storage
  logic             w_valid [WAYS];
  logic             w_dirty [WAYS];
  logic [TAG_W-1:0] w_tag   [WAYS];
  logic [BLK_W-1:0] w_data  [WAYS];
  logic [WAYS-1:0]  way_we;
  logic [WAYS-1:0]  hit_way;
  logic             wr_dirty;
  logic [BLK_W-1:0] wr_data;

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    cache2w_way #(.SET_W(SET_W), .TAG_W(TAG_W), .BLK_W(BLK_W)) u_way (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_set   (r_set),
      .rd_valid (w_valid[g]),
      .rd_dirty (w_dirty[g]),
      .rd_tag   (w_tag[g]),
      .rd_data  (w_data[g]),
      .wr_en    (way_we[g]),
      .wr_set   (r_set),
      .wr_dirty (wr_dirty),
      .wr_tag   (r_tag),
      .wr_data  (wr_data)
    );
    assign hit_way[g] = w_valid[g] && (w_tag[g] == r_tag);
  end

  // replacement
  logic vic;
  logic lru_touch;
  logic lru_way;

  cache2w_lru #(.SET_W(SET_W)) u_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_set    (r_set),
    .victim    (vic),
    .touch     (lru_touch),
    .touch_set (r_set),
    .used_way  (lru_way)
  );

  // named events for the checker
  logic hit_idx;
  logic req_wb;
  logic req_off;
  logic ev_hit;
  logic ev_miss;
  logic ev_fill_done;
  logic arr_write;
  assign hit_idx      = hit_way[1];
  assign req_wb       = (req_mode_q == MODE_WB);
  assign req_off      = (req_mode_q == MODE_OFF);
  assign ev_hit       = (state_q == ST_LOOK) && !req_off && (|hit_way);
  assign ev_miss      = (state_q == ST_LOOK) && !req_off && !(|hit_way);
  assign ev_fill_done = (state_q == ST_FILL) && mem_ready;
  assign arr_write    = |way_we;

  always_comb begin
    state_d   = state_q;
    way_we    = '0;
    wr_dirty  = 1'b0;
    wr_data   = w_data[hit_idx];
    lru_touch = 1'b0;
    lru_way   = hit_idx;
    resp_ld   = 1'b0;
    resp_d    = f_pick(mem_rdata, r_off);
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = {r_tag, r_set};
    mem_be    = '1;
    mem_wdata = w_data[vic];
    case (state_q)
      ST_IDLE: if (cpu_req) state_d = ST_LOOK;
      ST_LOOK: begin
        if (req_off) begin
          state_d = req_we_q ? ST_MWR : ST_MRD;
        end else if (|hit_way) begin
          lru_touch = 1'b1;
          if (req_we_q) begin
            way_we[hit_idx] = 1'b1;
            wr_data  = f_merge(w_data[hit_idx], r_off, req_wdata_q);
            wr_dirty = w_dirty[hit_idx] | req_wb;
            state_d  = req_wb ? ST_DONE : ST_MWR;
          end else begin
            resp_ld = 1'b1;
            resp_d  = f_pick(w_data[hit_idx], r_off);
            state_d = ST_DONE;
          end
        end else if (req_we_q && !req_wb) begin
          state_d = ST_MWR;
        end else if (w_valid[vic] && w_dirty[vic]) begin
          state_d = ST_EVICT;
        end else begin
          state_d = ST_FILL;
        end
      end
      ST_EVICT: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {w_tag[vic], r_set};
        if (mem_ready) state_d = ST_FILL;
      end
      ST_FILL: begin
        mem_valid = 1'b1;
        if (mem_ready) begin
          way_we[vic] = 1'b1;
          wr_data     = mem_rdata;
          state_d     = ST_LOOK;
        end
      end
      ST_MWR: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_be    = f_be(r_off);
        mem_wdata = {BLK_BYTES{req_wdata_q}};
        if (mem_ready) state_d = ST_DONE;
      end
      ST_MRD: begin
        mem_valid = 1'b1;
        if (mem_ready) begin
          resp_ld = 1'b1;
          state_d = ST_DONE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      req_addr_q  <= '0;
      req_we_q    <= 1'b0;
      req_wdata_q <= '0;
      req_mode_q  <= MODE_OFF;
      resp_q      <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && cpu_req) begin
        req_addr_q  <= cpu_addr;
        req_we_q    <= cpu_we;
        req_wdata_q <= cpu_wdata;
        req_mode_q  <= decode_mode(cfg_cd, cfg_nw);
      end
      if (resp_ld) resp_q <= resp_d;
    end
  end

  assign cpu_ready = (state_q == ST_DONE);
  assign cpu_rdata = resp_q;
endmodule

// File: rtl/cache2w_chk.sv
module cache2w_chk #(
  parameter int BADDR_W = 22,
  parameter int BLK_W   = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cpu_ready,
  input logic               mem_valid,
  input logic               mem_ready,
  input logic               mem_we,
  input logic [BADDR_W-1:0] mem_addr,
  input logic [BLK_W/8-1:0] mem_be,
  input logic [BLK_W-1:0]   mem_wdata,
  input logic [1:0]         hit_way,
  input logic               ev_hit,
  input logic               ev_miss,
  input logic               ev_fill_done,
  input logic               arr_write,
  input logic               req_we_q,
  input logic               req_wb,
  input logic               req_off
);

  p_one_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_way));

  p_mem_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_be) && $stable(mem_wdata));

  p_ready_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  p_fill_hits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill_done |=> ev_hit);

  p_miss_to_mem_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |=> mem_valid);

  p_wb_hit_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit && req_we_q && req_wb |=> !mem_valid);

  p_wb_full_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we && req_wb |-> (&mem_be));

  p_off_no_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
    arr_write |-> !req_off);

endmodule

bind cache2w cache2w_chk #(.BADDR_W(BADDR_W), .BLK_W(BLK_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_ready    (cpu_ready),
  .mem_valid    (mem_valid),
  .mem_ready    (mem_ready),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .mem_be       (mem_be),
  .mem_wdata    (mem_wdata),
  .hit_way      (hit_way),
  .ev_hit       (ev_hit),
  .ev_miss      (ev_miss),
  .ev_fill_done (ev_fill_done),
  .arr_write    (arr_write),
  .req_we_q     (req_we_q),
  .req_wb       (req_wb),
  .req_off      (req_off)
);

// File: tb/cache2w_bench.sv
`timescale 1ns/1ps
module cache2w_bench;
  localparam int ADDR_W = 24;
  localparam int SET_W  = 2;
  localparam int OFF_W  = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_cd = 1'b0;
  logic        cfg_nw = 1'b1;
  logic        cpu_req = 1'b0;
  logic        cpu_we = 1'b0;
  logic [23:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_ready;
  logic [7:0]  cpu_rdata;
  logic        mem_valid;
  logic        mem_we;
  logic [21:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  cache2w #(.ADDR_W(ADDR_W), .SET_W(SET_W), .OFF_W(OFF_W)) u_cache2w (
    .clk(clk), .rst_n(rst_n), .cfg_cd(cfg_cd), .cfg_nw(cfg_nw),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  int n_chk = 0;
  int n_err = 0;

  // memory behind the port, and the bench's expected image of it
  logic [31:0] mem     [16];
  logic [31:0] exp_mem [16];
  int act_rd = 0;
  int act_wr = 0;
  int delay = 0;

  // bench model of the cache lines
  logic        m_valid [4][2];
  logic        m_dirty [4][2];
  logic [1:0]  m_tag   [4][2];
  logic [31:0] m_data  [4][2];
  logic        m_lru   [4];

  always @(negedge clk) begin
    if (mem_ready) begin
      mem_ready = 1'b0;
    end else if (mem_valid) begin
      if (delay == 0) begin
        if (mem_we) begin
          for (int b = 0; b < 4; b++)
            if (mem_be[b]) mem[mem_addr[3:0]][8*b +: 8] = mem_wdata[8*b +: 8];
          act_wr++;
        end else begin
          mem_rdata = mem[mem_addr[3:0]];
          act_rd++;
        end
        mem_ready = 1'b1;
        delay = $urandom % 3;
      end else begin
        delay--;
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // expected outcome of one access, from the requirements
  task automatic model(input int mode, input logic we, input logic [1:0] t, input logic [1:0] s,
                       input logic [1:0] o, input logic [7:0] d,
                       output logic [7:0] q, output int rd, output int wr);
    int h;
    logic v;
    logic [3:0] bi;
    bi = {t, s};
    rd = 0; wr = 0; q = 8'h00; h = -1;
    if (mode >= 2) begin
      if (we) begin exp_mem[bi][{o, 3'b000} +: 8] = d; wr = 1; end
      else begin q = exp_mem[bi][{o, 3'b000} +: 8]; rd = 1; end
      return;
    end
    for (int w = 0; w < 2; w++) if (m_valid[s][w] && m_tag[s][w] == t) h = w;
    if (h < 0 && we && mode == 0) begin
      exp_mem[bi][{o, 3'b000} +: 8] = d;
      wr = 1;
      return;
    end
    if (h < 0) begin
      v = m_lru[s];
      if (m_valid[s][v] && m_dirty[s][v]) begin
        exp_mem[{m_tag[s][v], s}] = m_data[s][v];
        wr = 1;
      end
      m_data[s][v] = exp_mem[bi];
      m_valid[s][v] = 1'b1;
      m_tag[s][v] = t;
      m_dirty[s][v] = 1'b0;
      rd = 1;
      h = int'(v);
    end
    m_lru[s] = (h == 0);
    if (we) begin
      m_data[s][h][{o, 3'b000} +: 8] = d;
      if (mode == 1) m_dirty[s][h] = 1'b1;
      else begin exp_mem[bi][{o, 3'b000} +: 8] = d; wr = wr + 1; end
    end else begin
      q = m_data[s][h][{o, 3'b000} +: 8];
    end
  endtask

  // mode: 0 write-through, 1 write-back, 2 disabled (nw=0), 3 disabled (nw=1)
  task automatic run(input string tag, input int mode, input logic we, input logic [1:0] t,
                     input logic [1:0] s, input logic [1:0] o, input logic [7:0] d);
    logic [7:0] eq;
    int erd, ewr, rd0, wr0, first, bad;
    model(mode, we, t, s, o, d, eq, erd, ewr);
    rd0 = act_rd; wr0 = act_wr;
    cfg_cd = (mode >= 2);
    cfg_nw = (mode == 1) || (mode == 3);
    cpu_we = we;
    cpu_addr = {18'd0, t, s, o};
    cpu_wdata = d;
    cpu_req = 1'b1;
    first = 1;
    do begin
      @(negedge clk);
      if (first == 1) chk("R12", "ready in first cycle", 32'(cpu_ready), 32'd0);
      first = 0;
    end while (!cpu_ready);
    if (!we) chk(tag, "read byte", 32'(cpu_rdata), 32'(eq));
    cpu_req = 1'b0;
    chk(tag, "memory block reads", 32'(act_rd - rd0), 32'(erd));
    chk(tag, "memory writes", 32'(act_wr - wr0), 32'(ewr));
    bad = -1;
    for (int i = 0; i < 16; i++) if (bad < 0 && mem[i] !== exp_mem[i]) bad = i;
    n_chk++;
    if (bad >= 0) begin
      n_err++;
      $display("FAIL %s memory block %0d: actual %0h expected %0h", tag, bad, mem[bad], exp_mem[bad]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int mode;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 16; i++) begin
      mem[i] = 32'(i) * 32'h1122_3344 + 32'h0F1E_2D3C;
      exp_mem[i] = mem[i];
    end
    for (int s = 0; s < 4; s++) begin
      m_lru[s] = 1'b0;
      for (int w = 0; w < 2; w++) begin
        m_valid[s][w] = 1'b0; m_dirty[s][w] = 1'b0; m_tag[s][w] = '0; m_data[s][w] = '0;
      end
    end
    // R13: outputs idle during reset
    repeat (4) @(negedge clk);
    chk("R13", "cpu_ready in reset", 32'(cpu_ready), 32'd0);
    chk("R13", "mem_valid in reset", 32'(mem_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corner cases
    run("R13", 1, 1'b0, 2'd0, 2'd1, 2'd2, 8'h00);  // first access misses, fills line 0
    run("R2",  1, 1'b0, 2'd0, 2'd1, 2'd2, 8'h00);  // read hit, no traffic
    run("R6",  1, 1'b1, 2'd0, 2'd1, 2'd3, 8'hAA);  // write-back hit stays in line
    run("R6",  1, 1'b0, 2'd0, 2'd1, 2'd3, 8'h00);
    run("R1",  1, 1'b0, 2'd1, 2'd1, 2'd0, 8'h00);  // other tag, same set -> line 1
    run("R7",  1, 1'b0, 2'd2, 2'd1, 2'd1, 8'h00);  // evicts modified line 0
    run("R5",  1, 1'b0, 2'd1, 2'd1, 2'd0, 8'h00);  // line 1 still resident
    run("R7",  1, 1'b0, 2'd3, 2'd1, 2'd0, 8'h00);  // clean victim, no write
    run("R8",  0, 1'b1, 2'd3, 2'd1, 2'd0, 8'h55);  // write-through hit
    run("R9",  0, 1'b1, 2'd0, 2'd2, 2'd1, 8'h66);  // write-through miss, no allocate
    run("R9",  0, 1'b0, 2'd0, 2'd2, 2'd1, 8'h00);  // so this read misses
    run("R11", 2, 1'b0, 2'd3, 2'd1, 2'd0, 8'h00);  // disabled with nw=0
    run("R6",  1, 1'b1, 2'd3, 2'd1, 2'd1, 8'h77);
    run("R11", 3, 1'b1, 2'd3, 2'd1, 2'd1, 8'h99);  // disabled with nw=1 writes memory
    run("R10", 1, 1'b0, 2'd3, 2'd1, 2'd1, 8'h00);  // line untouched by bypass
    run("R4",  1, 1'b1, 2'd0, 2'd3, 2'd2, 8'hC3);  // write-back write miss allocates
    run("R4",  1, 1'b0, 2'd0, 2'd3, 2'd2, 8'h00);

    // constrained random traffic over four tags per set
    mode = 1;
    for (int n = 0; n < 600; n++) begin
      if (n % 16 == 0) mode = $urandom % 4;
      run(mode >= 2 ? "R10" : (mode == 1 ? "R7" : "R8"), mode, 1'($urandom % 2),
          2'($urandom), 2'($urandom), 2'($urandom), 8'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule